// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block resolves control flow for a RISC instruction set whose instructions each occupy 8 bytes. For every instruction presented with `in_valid`, it produces the address to fetch next, the computed destination address, a flag saying whether control actually moved, an optional write of a return address to the register file, and a fault flag for register-indirect jumps whose destination is not on an 8-byte boundary.

The surrounding pipeline supplies the opcode, the current PC, the 26-bit jump field, the 16-bit signed branch displacement, both source register values, the destination register index and the floating-point condition flag. The results appear on registered outputs one clock later, qualified by `out_valid`. Fetching, register storage and flushing stay with the caller. Only control opcodes are decoded. Any other opcode falls through as a plain sequential instruction.

Top module: `bnpc_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `taken`, `link_we` and `align_fault` read 0. Every instruction sampled with `in_valid` high at a rising edge produces its results, with `out_valid` high, right after that edge. Nothing is produced for cycles without `in_valid`.
- R2: The opcode values are: 0x01 direct jump, 0x02 direct jump with link, 0x03 register jump, 0x04 register jump with link, 0x05 branch if equal, 0x06 branch if not equal, 0x07 branch if at most zero, 0x08 branch if above zero, 0x09 branch if below zero, 0x0a branch if at least zero, 0x0b branch on FP flag clear, 0x0c branch on FP flag set. A direct jump (0x01, 0x02) is always taken. Its target is PC bits 31..28 followed by the 26-bit field and two zero bits.
- R3: Opcode 0x02 requests a link write of PC+8 to register 31. Opcode 0x04 requests a link write of PC+8 to the register named by `rd_idx`. No other opcode requests a link write.
- R4: For opcodes 0x05 to 0x0c, `target_pc` is PC+8 plus the sign-extended displacement times 4. This target is reported whether or not the branch is taken.
- R5: 0x05 is taken when `rs_val` equals `rt_val`. 0x06 is taken when they differ.
- R6: 0x07, 0x08, 0x09 and 0x0a are taken when `rs_val`, read as a signed two's-complement number, is ≤0, >0, <0 and ≥0 respectively.
- R7: 0x0b is taken when `fp_flag` is 0. 0x0c is taken when `fp_flag` is 1.
- R8: Opcodes 0x03 and 0x04 use `rs_val` as the target. If any of its low three bits is 1, `align_fault` is raised, and `taken` and `link_we` are both forced to 0.
- R9: `next_pc` equals `target_pc` when `taken` is 1. Otherwise it equals PC+8.
- R10: Any opcode outside 0x01..0x0c gives `next_pc` = `target_pc` = PC+8, with `taken`, `link_we` and `align_fault` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Instruction opcode |
| cur_pc | input | 32 | Address of the instruction |
| jump_field | input | 26 | Direct jump target field |
| br_offset | input | 16 | Signed branch displacement, in words |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| rd_idx | input | 5 | Link destination for the register jump with link |
| fp_flag | input | 1 | Floating-point condition flag |
| out_valid | output | 1 | Results below belong to an instruction |
| next_pc | output | 32 | Address to fetch next |
| target_pc | output | 32 | Computed destination address |
| taken | output | 1 | Control leaves the sequential path |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Register to receive the return address |
| link_val | output | 32 | Return address, PC+8 |
| align_fault | output | 1 | Register jump target not 8-byte aligned |

## Verification
The assertions check four properties on every cycle: the one-cycle valid latency, that a taken instruction fetches from its target and an untaken one from PC+8, that a fault never goes together with a taken flag or a link write, and that any link value equals the previous PC plus 8. Other behaviour needs the bench's stimulus, because the assertions do not know which opcode produced a result. This covers the opcode encodings, the target arithmetic (including negative displacements and the PC region bits of direct jumps), the signed compare at zero and at the sign boundary, and the choice of link register. The scoreboard compares each result against a model built from the requirements, over directed corners and a randomized mix with idle gaps.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_J    = 8'h01,
    OP_JAL  = 8'h02,
    OP_JR   = 8'h03,
    OP_JALR = 8'h04,
    OP_BEQ  = 8'h05,
    OP_BNE  = 8'h06,
    OP_BLEZ = 8'h07,
    OP_BGTZ = 8'h08,
    OP_BLTZ = 8'h09,
    OP_BGEZ = 8'h0a,
    OP_BFPF = 8'h0b,
    OP_BFPT = 8'h0c
  } ctl_op_e;

  typedef enum logic [1:0] {
    FLOW_SEQ,
    FLOW_DIRECT,
    FLOW_INDIRECT,
    FLOW_BRANCH
  } flow_e;

  typedef enum logic [3:0] {
    TEST_NONE,
    TEST_EQ,
    TEST_NE,
    TEST_LEZ,
    TEST_GTZ,
    TEST_LTZ,
    TEST_GEZ,
    TEST_FCLR,
    TEST_FSET
  } test_e;

  typedef struct packed {
    flow_e flow;
    test_e test;
    logic  link_fixed;
    logic  link_rd;
  } ctl_dec_t;

endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
  import bnpc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctl_dec_t         dec
);

  always_comb begin
    dec.flow       = FLOW_SEQ;
    dec.test       = TEST_NONE;
    dec.link_fixed = 1'b0;
    dec.link_rd    = 1'b0;
    case (opcode)
      OP_J:    dec.flow = FLOW_DIRECT;
      OP_JAL: begin
        dec.flow       = FLOW_DIRECT;
        dec.link_fixed = 1'b1;
      end
      OP_JR:   dec.flow = FLOW_INDIRECT;
      OP_JALR: begin
        dec.flow    = FLOW_INDIRECT;
        dec.link_rd = 1'b1;
      end
      OP_BEQ: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_EQ;
      end
      OP_BNE: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_NE;
      end
      OP_BLEZ: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_LEZ;
      end
      OP_BGTZ: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_GTZ;
      end
      OP_BLTZ: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_LTZ;
      end
      OP_BGEZ: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_GEZ;
      end
      OP_BFPF: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_FCLR;
      end
      OP_BFPT: begin
        dec.flow = FLOW_BRANCH;
        dec.test = TEST_FSET;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bnpc_cond.sv
module bnpc_cond
  import bnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  test_e           test,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic            fp_flag,
  output logic            cond_ok
);

  logic rs_neg;
  logic rs_zero;
  logic ops_equal;

  assign rs_neg    = rs_val[XLEN-1];
  assign rs_zero   = (rs_val == '0);
  assign ops_equal = (rs_val == rt_val);

  always_comb begin
    case (test)
      TEST_EQ:   cond_ok = ops_equal;
      TEST_NE:   cond_ok = !ops_equal;
      TEST_LEZ:  cond_ok = rs_neg || rs_zero;
      TEST_GTZ:  cond_ok = !rs_neg && !rs_zero;
      TEST_LTZ:  cond_ok = rs_neg;
      TEST_GEZ:  cond_ok = !rs_neg;
      TEST_FCLR: cond_ok = !fp_flag;
      TEST_FSET: cond_ok = fp_flag;
      default:   cond_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
  import bnpc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int XLEN       = 32,
  parameter int TARG_W     = 26,
  parameter int OFS_W      = 16,
  parameter int TGT_SHIFT  = 2,
  parameter int INST_BYTES = 8,
  parameter int ALIGN_BITS = 3
) (
  input  flow_e             flow,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [TARG_W-1:0] jump_field,
  input  logic [OFS_W-1:0]  br_offset,
  input  logic [XLEN-1:0]   rs_val,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   tgt_pc,
  output logic              misalign
);

  localparam int JLOW = TARG_W + TGT_SHIFT;

  logic [PC_W-1:0] direct_pc;
  logic [PC_W-1:0] branch_pc;
  logic [PC_W-1:0] indirect_pc;
  logic [PC_W-1:0] ofs_ext;

  assign seq_pc = cur_pc + PC_W'(INST_BYTES);

  // region-preserving direct target
  generate
    if (JLOW < PC_W) begin : g_dir_region
      assign direct_pc = {cur_pc[PC_W-1:JLOW], jump_field, {TGT_SHIFT{1'b0}}};
    end else begin : g_dir_full
      assign direct_pc = PC_W'({jump_field, {TGT_SHIFT{1'b0}}});
    end
  endgenerate

  // displacement measured from the sequential address
  assign ofs_ext   = {{(PC_W-OFS_W){br_offset[OFS_W-1]}}, br_offset};
  assign branch_pc = seq_pc + (ofs_ext << TGT_SHIFT);

  generate
    if (XLEN >= PC_W) begin : g_ind_trunc
      assign indirect_pc = rs_val[PC_W-1:0];
    end else begin : g_ind_ext
      assign indirect_pc = {{(PC_W-XLEN){1'b0}}, rs_val};
    end
  endgenerate

  generate
    if (ALIGN_BITS > 0) begin : g_align_chk
      assign misalign = |rs_val[ALIGN_BITS-1:0];
    end else begin : g_align_none
      assign misalign = 1'b0;
    end
  endgenerate

  always_comb begin
    case (flow)
      FLOW_DIRECT:   tgt_pc = direct_pc;
      FLOW_INDIRECT: tgt_pc = indirect_pc;
      FLOW_BRANCH:   tgt_pc = branch_pc;
      default:       tgt_pc = seq_pc;
    endcase
  end

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int XLEN       = 32,
  parameter int TARG_W     = 26,
  parameter int OFS_W      = 16,
  parameter int REG_IDX_W  = 5,
  parameter int LINK_REG   = 31,
  parameter int TGT_SHIFT  = 2,
  parameter int INST_BYTES = 8,
  parameter int ALIGN_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [OPC_W-1:0]     opcode,
  input  logic [PC_W-1:0]      cur_pc,
  input  logic [TARG_W-1:0]    jump_field,
  input  logic [OFS_W-1:0]     br_offset,
  input  logic [XLEN-1:0]      rs_val,
  input  logic [XLEN-1:0]      rt_val,
  input  logic [REG_IDX_W-1:0] rd_idx,
  input  logic                 fp_flag,
  output logic                 out_valid,
  output logic [PC_W-1:0]      next_pc,
  output logic [PC_W-1:0]      target_pc,
  output logic                 taken,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]      link_val,
  output logic                 align_fault
);

  ctl_dec_t             dec;
  logic                 cond_ok;
  logic [PC_W-1:0]      seq_pc;
  logic [PC_W-1:0]      tgt_pc;
  logic                 misalign;
  logic                 fault_c;
  logic                 taken_c;
  logic                 link_c;
  logic [REG_IDX_W-1:0] link_idx_c;
  logic [PC_W-1:0]      next_c;

  bnpc_decode u_decode (
    .opcode (opcode),
    .dec    (dec)
  );

  bnpc_cond #(
    .XLEN (XLEN)
  ) u_cond (
    .test    (dec.test),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .fp_flag (fp_flag),
    .cond_ok (cond_ok)
  );

  bnpc_target #(
    .PC_W       (PC_W),
    .XLEN       (XLEN),
    .TARG_W     (TARG_W),
    .OFS_W      (OFS_W),
    .TGT_SHIFT  (TGT_SHIFT),
    .INST_BYTES (INST_BYTES),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_target (
    .flow       (dec.flow),
    .cur_pc     (cur_pc),
    .jump_field (jump_field),
    .br_offset  (br_offset),
    .rs_val     (rs_val),
    .seq_pc     (seq_pc),
    .tgt_pc     (tgt_pc),
    .misalign   (misalign)
  );

  // resolution of the control decision
  assign fault_c    = (dec.flow == FLOW_INDIRECT) && misalign;
  assign taken_c    = (dec.flow == FLOW_DIRECT)
                   || ((dec.flow == FLOW_INDIRECT) && !misalign)
                   || ((dec.flow == FLOW_BRANCH) && cond_ok);
  assign link_c     = (dec.link_fixed || dec.link_rd) && !fault_c;
  assign link_idx_c = dec.link_fixed ? REG_IDX_W'(LINK_REG) : rd_idx;
  assign next_c     = taken_c ? tgt_pc : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      next_pc     <= '0;
      target_pc   <= '0;
      taken       <= 1'b0;
      link_we     <= 1'b0;
      link_idx    <= '0;
      link_val    <= '0;
      align_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc     <= next_c;
        target_pc   <= tgt_pc;
        taken       <= taken_c;
        link_we     <= link_c;
        link_idx    <= link_c ? link_idx_c : '0;
        link_val    <= XLEN'(seq_pc);
        align_fault <= fault_c;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1

  AST_TAKEN_TO_TARGET: assert property (@(posedge clk) disable iff (rst)
    (out_valid && taken) |-> (next_pc == target_pc)); // R9

  AST_UNTAKEN_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken) |-> (next_pc == $past(cur_pc) + PC_W'(INST_BYTES))); // R9

  AST_FAULT_BLOCKS_FLOW: assert property (@(posedge clk) disable iff (rst)
    (out_valid && align_fault) |-> (!taken && !link_we)); // R8

  AST_LINK_RETURN_ADDR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && link_we) |-> (link_val == XLEN'($past(cur_pc) + PC_W'(INST_BYTES)))); // R3

endmodule

// File: tb/bnpc_unit_tb.sv
`timescale 1ns/1ps
module bnpc_unit_tb;

  typedef struct {
    logic [31:0] npc;
    logic [31:0] tgt;
    logic        tkn;
    logic        lwe;
    logic [4:0]  lidx;
    logic [31:0] lval;
    logic        flt;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [31:0] cur_pc = '0;
  logic [25:0] jump_field = '0;
  logic [15:0] br_offset = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [4:0]  rd_idx = '0;
  logic        fp_flag = 1'b0;
  logic        out_valid;
  logic [31:0] next_pc;
  logic [31:0] target_pc;
  logic        taken;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_val;
  logic        align_fault;

  int   n_vec = 0;
  int   n_bad = 0;
  exp_t sb_q[$];
  bit   done = 0;

  always #4 clk = ~clk;

  bnpc_unit u_dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .opcode      (opcode),
    .cur_pc      (cur_pc),
    .jump_field  (jump_field),
    .br_offset   (br_offset),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .rd_idx      (rd_idx),
    .fp_flag     (fp_flag),
    .out_valid   (out_valid),
    .next_pc     (next_pc),
    .target_pc   (target_pc),
    .taken       (taken),
    .link_we     (link_we),
    .link_idx    (link_idx),
    .link_val    (link_val),
    .align_fault (align_fault)
  );

  // reference model written from the requirements
  function automatic exp_t model(input logic [7:0] op, input logic [31:0] pc,
                                 input logic [25:0] jf, input logic [15:0] ofs,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [4:0] rd, input logic fp);
    exp_t e;
    logic [31:0] seq;
    logic [31:0] btgt;
    logic        cond;
    seq    = pc + 32'd8;
    btgt   = seq + ({{16{ofs[15]}}, ofs} * 32'd4);
    e.npc  = seq;
    e.tgt  = seq;
    e.tkn  = 1'b0;
    e.lwe  = 1'b0;
    e.lidx = 5'd0;
    e.lval = seq;
    e.flt  = 1'b0;
    e.tag  = "R10";
    cond   = 1'b0;
    if (op == 8'h01 || op == 8'h02) begin
      e.tgt = {pc[31:28], jf, 2'b00};
      e.tkn = 1'b1;
      e.tag = "R2,R9";
      if (op == 8'h02) begin
        e.lwe  = 1'b1;
        e.lidx = 5'd31;
        e.tag  = "R2,R3";
      end
    end else if (op == 8'h03 || op == 8'h04) begin
      e.tgt = a;
      e.flt = (a[2:0] != 3'b000);
      e.tkn = !e.flt;
      e.tag = "R8";
      if (op == 8'h04 && !e.flt) begin
        e.lwe  = 1'b1;
        e.lidx = rd;
        e.tag  = "R3,R8";
      end
    end else if (op >= 8'h05 && op <= 8'h0c) begin
      e.tgt = btgt;
      case (op)
        8'h05: begin cond = (a == b);              e.tag = "R5,R4"; end
        8'h06: begin cond = (a != b);              e.tag = "R5,R4"; end
        8'h07: begin cond = ($signed(a) <= 0);     e.tag = "R6,R4"; end
        8'h08: begin cond = ($signed(a) > 0);      e.tag = "R6,R4"; end
        8'h09: begin cond = ($signed(a) < 0);      e.tag = "R6,R4"; end
        8'h0a: begin cond = ($signed(a) >= 0);     e.tag = "R6,R4"; end
        8'h0b: begin cond = !fp;                   e.tag = "R7,R4"; end
        default: begin cond = fp;                  e.tag = "R7,R4"; end
      endcase
      e.tkn = cond;
    end
    if (e.tkn) e.npc = e.tgt;
    return e;
  endfunction

  task automatic report_bad(input string tag, input string fld,
                            input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
  endtask

  task automatic apply(input logic [7:0] op, input logic [31:0] pc,
                       input logic [25:0] jf, input logic [15:0] ofs,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] rd, input logic fp);
    @(negedge clk);
    opcode     = op;
    cur_pc     = pc;
    jump_field = jf;
    br_offset  = ofs;
    rs_val     = a;
    rt_val     = b;
    rd_idx     = rd;
    fp_flag    = fp;
    in_valid   = 1'b1;
    sb_q.push_back(model(op, pc, jf, ofs, a, b, rd, fp));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opcode   = 8'h05;
      rs_val   = 32'hdead_beef;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          n_vec++;
          report_bad("R1", "unexpected out_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          n_vec++;
          if (next_pc !== e.npc)       report_bad({e.tag, ",R9"}, "next_pc", next_pc, e.npc);
          if (target_pc !== e.tgt)     report_bad(e.tag, "target_pc", target_pc, e.tgt);
          if (taken !== e.tkn)         report_bad(e.tag, "taken", 32'(taken), 32'(e.tkn));
          if (link_we !== e.lwe)       report_bad(e.tag, "link_we", 32'(link_we), 32'(e.lwe));
          if (align_fault !== e.flt)   report_bad(e.tag, "align_fault", 32'(align_fault), 32'(e.flt));
          if (e.lwe) begin
            if (link_idx !== e.lidx)   report_bad(e.tag, "link_idx", 32'(link_idx), 32'(e.lidx));
            if (link_val !== e.lval)   report_bad(e.tag, "link_val", link_val, e.lval);
          end
        end
      end else if (sb_q.size() > 1) begin
        n_vec++;
        report_bad("R1", "result latency", 32'(sb_q.size()), 32'd1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", sb_q.size());
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    n_vec++;
    if (out_valid !== 1'b0 || taken !== 1'b0 || link_we !== 1'b0 || align_fault !== 1'b0)
      report_bad("R1", "reset outputs",
                 {28'd0, out_valid, taken, link_we, align_fault}, 32'd0);
    rst = 1'b0;
    idle(2);

    // R2: direct jumps keep the PC region bits
    apply(8'h01, 32'hA000_1230, 26'h3FF_FFFF, 16'h0, 32'h0, 32'h0, 5'd0, 1'b0);
    apply(8'h02, 32'h7FFF_FFF8, 26'h000_0010, 16'h0, 32'h0, 32'h0, 5'd9, 1'b0);
    // R8/R3: register jumps
    apply(8'h03, 32'h0000_1000, 26'h0, 16'h0, 32'h0040_0008, 32'h0, 5'd0, 1'b0);
    apply(8'h03, 32'h0000_1000, 26'h0, 16'h0, 32'h0040_0004, 32'h0, 5'd0, 1'b0);
    apply(8'h04, 32'h0000_2000, 26'h0, 16'h0, 32'h1234_5670, 32'h0, 5'd7, 1'b0);
    apply(8'h04, 32'h0000_2000, 26'h0, 16'h0, 32'h1234_5671, 32'h0, 5'd7, 1'b0);
    apply(8'h04, 32'h0000_2000, 26'h0, 16'h0, 32'h1234_5672, 32'h0, 5'd3, 1'b0);
    idle(1);
    // R5: equality branches, positive and negative displacement
    apply(8'h05, 32'h0000_4000, 26'h0, 16'h0010, 32'h55, 32'h55, 5'd0, 1'b0);
    apply(8'h05, 32'h0000_4000, 26'h0, 16'hFFF0, 32'h55, 32'h54, 5'd0, 1'b0);
    apply(8'h06, 32'h0000_4000, 26'h0, 16'hFFF0, 32'h55, 32'h54, 5'd0, 1'b0);
    apply(8'h06, 32'h0000_4000, 26'h0, 16'h7FFF, 32'h9, 32'h9, 5'd0, 1'b0);
    // R6: signed compares at zero and at the sign boundary
    apply(8'h07, 32'h0000_8000, 26'h0, 16'h0004, 32'h0, 32'h0, 5'd0, 1'b0);
    apply(8'h07, 32'h0000_8000, 26'h0, 16'h0004, 32'h7FFF_FFFF, 32'h0, 5'd0, 1'b0);
    apply(8'h08, 32'h0000_8000, 26'h0, 16'h0004, 32'h0, 32'h0, 5'd0, 1'b0);
    apply(8'h08, 32'h0000_8000, 26'h0, 16'h0004, 32'h0000_0001, 32'h0, 5'd0, 1'b0);
    apply(8'h09, 32'h0000_8000, 26'h0, 16'h8000, 32'h8000_0000, 32'h0, 5'd0, 1'b0);
    apply(8'h09, 32'h0000_8000, 26'h0, 16'h8000, 32'h0, 32'h0, 5'd0, 1'b0);
    apply(8'h0a, 32'h0000_8000, 26'h0, 16'h0001, 32'h0, 32'h0, 5'd0, 1'b0);
    apply(8'h0a, 32'h0000_8000, 26'h0, 16'h0001, 32'hFFFF_FFFF, 32'h0, 5'd0, 1'b0);
    // R7: FP flag branches
    apply(8'h0b, 32'h0001_0000, 26'h0, 16'h0020, 32'h0, 32'h0, 5'd0, 1'b0);
    apply(8'h0b, 32'h0001_0000, 26'h0, 16'h0020, 32'h0, 32'h0, 5'd0, 1'b1);
    apply(8'h0c, 32'h0001_0000, 26'h0, 16'h0020, 32'h0, 32'h0, 5'd0, 1'b1);
    apply(8'h0c, 32'h0001_0000, 26'h0, 16'h0020, 32'h0, 32'h0, 5'd0, 1'b0);
    // R10: non-control opcodes, including PC wrap
    apply(8'h00, 32'h0000_0100, 26'h3FF_FFFF, 16'hFFFF, 32'h8, 32'h8, 5'd31, 1'b1);
    apply(8'h0d, 32'h0000_0100, 26'h1, 16'h1, 32'h8, 32'h8, 5'd31, 1'b1);
    apply(8'h40, 32'hFFFF_FFF8, 26'h1, 16'h1, 32'h8, 32'h8, 5'd31, 1'b1);
    apply(8'hFF, 32'h0000_0100, 26'h1, 16'h1, 32'h8, 32'h8, 5'd31, 1'b1);
    idle(2);

    // randomized mix with gaps (R2..R10)
    for (int k = 0; k < 400; k++) begin
      logic [7:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      op = 8'($urandom_range(0, 15));
      a  = $urandom;
      if ($urandom_range(0, 1) == 0) a[2:0] = 3'b000;
      if ($urandom_range(0, 3) == 0) a = 32'h0;
      b  = ($urandom_range(0, 1) == 0) ? a : $urandom;
      apply(op, {$urandom} & 32'hFFFF_FFF8, 26'($urandom), 16'($urandom), a, b,
            5'($urandom), 1'($urandom));
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(4);
    if (sb_q.size() != 0) begin
      n_vec++;
      report_bad("R1", "results missing", 32'(sb_q.size()), 32'd0);
    end
    done = 1;
    finish_run();
  end

endmodule